// File: doc/BRIEF.md
# Random MSB Segment Shuffler

This block sits in front of a segmented current-steering DAC. The DAC's most significant cells are split into four equal quarters. The block takes the MSB field of each output sample as a count of cells to turn on. It divides that count as evenly as it can among the quarters and drives a thermometer enable vector covering every cell. The mapping is latched on each update strobe, so the analog array sees a new pattern exactly once per sample.

The quarters that take the remainder cells follow a quarter order. That order is one of the 24 permutations of the four quarters. With shuffling switched on, a new permutation is drawn from an LFSR after every 4, 8 or 16 strobes, as selected. The new order applies from the strobe after the period boundary, so no sample mixes two mappings. With shuffling switched off, the order stays at the identity permutation. In every order, a code turns on the same total number of cells, and only their placement moves.

Top module: `seg_shuffler`

## Requirements
- R1: After reset, `cellEn` is all zero, the strobe counter is zero, the permutation index is 0 (identity) and the LFSR holds 8'h01.
- R2: On a clock edge with `updStb` high, `cellEn` takes the mapping of the `msbCode` sampled at that edge, visible after the edge. Its total number of ones equals `msbCode`. Without a strobe, `cellEn` holds its value.
- R3: Quarter q drives `cellEn[4q+3:4q]` and is filled from its lowest bit upward. Each quarter has base = msbCode/4 cells on, plus one more for quarters that take a remainder cell.
- R4: Let the quarter order be order[0..3], and let rem = msbCode mod 4. The quarters order[0] to order[rem-1] each take one extra cell. The order is decoded from the permutation index i (0..23) using the digits d0 = i/6, d1 = (i mod 6)/2 and d2 = i mod 2. Each digit picks, by position, one entry of the list of still-unused quarters (starting from 0,1,2,3), and the pick is removed from the list. The last unused quarter becomes order[3].
- R5: `perSel` sets the period length P to 4 (0), 8 (1) or 16 (2 or 3). The counter advances on each strobe while enabled. On a strobe with counter >= P-1, the counter returns to 0 and a new permutation is loaded. The new permutation governs strobes from the next one onward.
- R6: The LFSR is 8 bits. Its next value is {l[6:0], l[7]^l[5]^l[4]^l[3]}, and it advances only on a period boundary. The new permutation index is that next value mod 24.
- R7: While `shufEn` is low, every clock forces the permutation index to 0 and the counter to 0, and the LFSR holds. The mapping is then fixed at the identity order, whatever strobes arrive.
- R8: Code 0 turns every cell off. Code 15 turns on 15 cells: quarters order[0..2] are full and quarter order[3] has 3 cells on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msbCode | input | 4 | MSB field: number of cells to enable |
| updStb | input | 1 | Output update strobe, one per DAC sample |
| shufEn | input | 1 | Shuffling enable |
| perSel | input | 2 | Shuffle period select |
| cellEn | output | 16 | Thermometer enables, 4 cells per quarter |

## Verification
The bench keeps a cycle model of the counter, the LFSR and the permutation. It compares every cell bit after every clock, so a permutation that took effect one strobe early or late would show up as misplaced remainder cells right at the period boundary. It changes `perSel` in mid-period to a shorter period. A design that compared only for equality with P-1 would run its counter past the boundary and miss the next reshuffle. It toggles `shufEn` with strobes present, which catches a design that keeps the old order or lets the LFSR advance while disabled. Codes 0, 15 and exact multiples of four test the remainder arithmetic, where an off-by-one would light the wrong quarter or change the total cell count.

// File: rtl/seg_shuffler_pkg.sv
package seg_shuffler_pkg;

  localparam int NUM_Q = 4;
  localparam int PERM_COUNT = 24;
  localparam int PERM_W = 5;

  typedef logic [NUM_Q-1:0][1:0] qOrder_t;

  typedef struct packed {
    logic capture;
    logic [PERM_W-1:0] permIdx;
  } shufCtl_t;

  // Lehmer-style decode of a permutation index into a quarter order.
  function automatic qOrder_t decodePerm(input logic [PERM_W-1:0] idx);
    logic [1:0] pool [NUM_Q];
    logic [1:0] digit [NUM_Q];
    qOrder_t res;
    int iv;
    iv = int'(idx);
    for (int m = 0; m < NUM_Q; m++) pool[m] = 2'(m);
    digit[0] = 2'(iv / 6);
    digit[1] = 2'((iv % 6) / 2);
    digit[2] = 2'(iv % 2);
    digit[3] = 2'd0;
    for (int k = 0; k < NUM_Q; k++) begin
      res[k] = pool[digit[k]];
      for (int m = 0; m < NUM_Q - 1; m++) begin
        if (2'(m) >= digit[k]) pool[m] = pool[m+1];
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/seg_shuffle_ctrl.sv
module seg_shuffle_ctrl
  import seg_shuffler_pkg::*;
#(
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 8'h01,
  parameter int MAX_PERIOD = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       updStb,
  input  logic       shufEn,
  input  logic [1:0] perSel,
  output shufCtl_t   ctl
);

  localparam int CNT_W = $clog2(MAX_PERIOD);

  logic [CNT_W-1:0] strobeCnt;
  logic [CNT_W-1:0] lastIdx;
  logic [LFSR_W-1:0] lfsrQ;
  logic [LFSR_W-1:0] lfsrNxt;
  logic [PERM_W-1:0] permIdx;
  logic boundary;

  always_comb begin
    case (perSel)
      2'd0:    lastIdx = CNT_W'(3);
      2'd1:    lastIdx = CNT_W'(7);
      default: lastIdx = CNT_W'(MAX_PERIOD - 1);
    endcase
  end

  assign lfsrNxt  = {lfsrQ[LFSR_W-2:0], lfsrQ[7] ^ lfsrQ[5] ^ lfsrQ[4] ^ lfsrQ[3]};
  assign boundary = updStb && (strobeCnt >= lastIdx);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeCnt <= '0;
      lfsrQ     <= LFSR_SEED;
      permIdx   <= '0;
    end else if (!shufEn) begin
      strobeCnt <= '0;
      permIdx   <= '0;
    end else if (boundary) begin
      strobeCnt <= '0;
      lfsrQ     <= lfsrNxt;
      permIdx   <= PERM_W'(lfsrNxt % LFSR_W'(PERM_COUNT));
    end else if (updStb) begin
      strobeCnt <= strobeCnt + 1'b1;
    end
  end

  assign ctl.capture = updStb;
  assign ctl.permIdx = permIdx;

  a_r7_disabled_identity: assert property (@(posedge clk) disable iff (!rstN)
    !shufEn |=> (permIdx == '0 && strobeCnt == '0));
  a_r5_perm_hold_mid_period: assert property (@(posedge clk) disable iff (!rstN)
    (shufEn && !updStb) |=> $stable(permIdx));
  a_r6_perm_range: assert property (@(posedge clk) disable iff (!rstN)
    permIdx < PERM_W'(PERM_COUNT));
  a_r6_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);
  a_r5_counter_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (shufEn && boundary) |=> strobeCnt == '0);

endmodule

// File: rtl/seg_shuffle_dpath.sv
module seg_shuffle_dpath
  import seg_shuffler_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [CODE_W-1:0]       msbCode,
  input  shufCtl_t                ctl,
  output logic [2**CODE_W-1:0]    cellEn
);

  localparam int CELLS = 2**CODE_W;
  localparam int CELLS_Q = CELLS / NUM_Q;
  localparam int CNT_W = CODE_W - 1;

  qOrder_t order;
  logic [CNT_W-1:0] baseCnt;
  logic [1:0] remCnt;
  logic [CNT_W-1:0] qCnt [NUM_Q];
  logic [CELLS-1:0] thermo;

  always_comb begin
    order   = decodePerm(ctl.permIdx);
    baseCnt = CNT_W'(msbCode >> 2);
    remCnt  = msbCode[1:0];
    for (int q = 0; q < NUM_Q; q++) begin
      qCnt[q] = baseCnt;
      for (int k = 0; k < NUM_Q; k++) begin
        if (order[k] == 2'(q) && 2'(k) < remCnt) qCnt[q] = baseCnt + 1'b1;
      end
    end
  end

  for (genvar gq = 0; gq < NUM_Q; gq++) begin : g_quarter
    for (genvar gj = 0; gj < CELLS_Q; gj++) begin : g_cell
      assign thermo[gq*CELLS_Q + gj] = (CNT_W'(gj) < qCnt[gq]);
    end

    a_r3_quarter_share: assert property (@(posedge clk) disable iff (!rstN)
      ctl.capture |=>
        ($countones(cellEn[gq*CELLS_Q +: CELLS_Q]) == int'($past(msbCode) >> 2) ||
         $countones(cellEn[gq*CELLS_Q +: CELLS_Q]) == int'($past(msbCode) >> 2) + 1));
    a_r3_thermo_shape: assert property (@(posedge clk) disable iff (!rstN)
      (cellEn[gq*CELLS_Q +: CELLS_Q] &
       (cellEn[gq*CELLS_Q +: CELLS_Q] + CELLS_Q'(1))) == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cellEn <= '0;
    else if (ctl.capture) cellEn <= thermo;
  end

  a_r2_total_cells: assert property (@(posedge clk) disable iff (!rstN)
    ctl.capture |=> $countones(cellEn) == int'($past(msbCode)));
  a_r2_hold_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(cellEn));

endmodule

// File: rtl/seg_shuffler.sv
module seg_shuffler
  import seg_shuffler_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int LFSR_W = 8,
  parameter int MAX_PERIOD = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CODE_W-1:0]    msbCode,
  input  logic                 updStb,
  input  logic                 shufEn,
  input  logic [1:0]           perSel,
  output logic [2**CODE_W-1:0] cellEn
);

  shufCtl_t ctl;

  seg_shuffle_ctrl #(
    .LFSR_W(LFSR_W),
    .LFSR_SEED(LFSR_W'(1)),
    .MAX_PERIOD(MAX_PERIOD)
  ) u_ctrl (
    .clk(clk),
    .rstN(rstN),
    .updStb(updStb),
    .shufEn(shufEn),
    .perSel(perSel),
    .ctl(ctl)
  );

  seg_shuffle_dpath #(
    .CODE_W(CODE_W)
  ) u_dpath (
    .clk(clk),
    .rstN(rstN),
    .msbCode(msbCode),
    .ctl(ctl),
    .cellEn(cellEn)
  );

endmodule

// File: tb/seg_shuffler_tb.sv
module seg_shuffler_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] msbCode = '0;
  logic updStb = 1'b0;
  logic shufEn = 1'b0;
  logic [1:0] perSel = '0;
  logic [15:0] cellEn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int bCnt;
  int bPerm;
  logic [7:0] bLfsr;
  logic [15:0] bOut;

  always #10 clk = ~clk;

  seg_shuffler u_dut (
    .clk(clk), .rstN(rstN), .msbCode(msbCode), .updStb(updStb),
    .shufEn(shufEn), .perSel(perSel), .cellEn(cellEn)
  );

  function automatic logic [15:0] expMap(input int code, input int pidx);
    int avail [4];
    int ord [4];
    int dg [3];
    int n;
    int cnt;
    logic [15:0] v;
    dg[0] = pidx / 6;
    dg[1] = (pidx % 6) / 2;
    dg[2] = pidx % 2;
    for (int m = 0; m < 4; m++) avail[m] = m;
    n = 4;
    for (int k = 0; k < 3; k++) begin
      ord[k] = avail[dg[k]];
      for (int m = dg[k]; m < n - 1; m++) avail[m] = avail[m+1];
      n--;
    end
    ord[3] = avail[0];
    v = '0;
    for (int k = 0; k < 4; k++) begin
      cnt = code / 4 + ((k < code % 4) ? 1 : 0);
      for (int j = 0; j < cnt; j++) v[ord[k]*4 + j] = 1'b1;
    end
    return v;
  endfunction

  function automatic int periodOf(input logic [1:0] s);
    return (s == 2'd0) ? 4 : (s == 2'd1) ? 8 : 16;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // One clock: drive inputs, advance the model at the edge, check after it.
  task automatic tick(input int code, input bit stb, input bit en, input logic [1:0] sel, input string tag);
    msbCode = 4'(code);
    updStb = stb;
    shufEn = en;
    perSel = sel;
    @(posedge clk);
    if (stb) bOut = expMap(code, bPerm);
    if (!en) begin
      bCnt = 0;
      bPerm = 0;
    end else if (stb) begin
      if (bCnt >= periodOf(sel) - 1) begin
        bLfsr = {bLfsr[6:0], bLfsr[7] ^ bLfsr[5] ^ bLfsr[4] ^ bLfsr[3]};
        bPerm = int'(bLfsr) % 24;
        bCnt = 0;
      end else begin
        bCnt++;
      end
    end
    @(negedge clk);
    updStb = 1'b0;
    check(cellEn === bOut, tag, cellEn, bOut);
    if (stb) check($countones(cellEn) == code, "R2 total cells", cellEn, 16'(code));
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int code;
    bit en;
    logic [1:0] sel;
    void'($urandom(32'd1234));
    bCnt = 0;
    bPerm = 0;
    bLfsr = 8'h01;
    bOut = '0;
    repeat (3) @(negedge clk);
    check(cellEn === 16'h0, "R1 reset output", cellEn, 16'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(cellEn === 16'h0, "R1 after reset release", cellEn, 16'h0);

    // R7 / R3 / R4: identity order across every code while disabled
    for (int c = 0; c < 16; c++) tick(c, 1'b1, 1'b0, 2'd0, "R7 R3 R4 identity map");
    tick(0, 1'b1, 1'b0, 2'd0, "R8 code zero");
    check(cellEn === 16'h0, "R8 code zero all off", cellEn, 16'h0);
    tick(15, 1'b1, 1'b0, 2'd0, "R8 code fifteen");
    check(cellEn === 16'h7FFF, "R8 identity full scale", cellEn, 16'h7FFF);
    tick(5, 1'b0, 1'b0, 2'd0, "R2 hold without strobe");

    // R5 / R6: shuffling with each period select
    for (int s = 0; s < 4; s++) begin
      for (int n = 0; n < 40; n++) begin
        tick(int'($urandom_range(15)), 1'b1, 1'b1, 2'(s), "R5 R6 periodic shuffle");
        if (n % 7 == 3) tick(9, 1'b0, 1'b1, 2'(s), "R2 R5 hold between strobes");
      end
    end

    // R5: shrink period in mid-run (counter above new last index)
    for (int n = 0; n < 12; n++) tick(n, 1'b1, 1'b1, 2'd2, "R5 long period run");
    for (int n = 0; n < 12; n++) tick(15 - n, 1'b1, 1'b1, 2'd0, "R5 period shrink");

    // R7: disable mid-period, strobes ignored for shuffle state
    for (int n = 0; n < 6; n++) tick(n + 3, 1'b1, 1'b0, 2'd0, "R7 disabled strobes");
    for (int n = 0; n < 10; n++) tick(n + 2, 1'b1, 1'b1, 2'd0, "R7 R6 re-enable");

    // Random mix
    en = 1'b1;
    sel = 2'd1;
    for (int n = 0; n < 1500; n++) begin
      if ($urandom_range(99) < 4) en = ~en;
      if ($urandom_range(99) < 5) sel = 2'($urandom_range(3));
      code = int'($urandom_range(15));
      if ($urandom_range(9) == 0) code = ($urandom_range(1) == 0) ? 0 : 15;
      tick(code, ($urandom_range(99) < 70), en, sel, "R2 R3 R4 R5 R6 R7 random mix");
    end

    // R1: reset mid-run returns to initial state
    rstN = 1'b0;
    @(negedge clk);
    check(cellEn === 16'h0, "R1 mid-run reset", cellEn, 16'h0);
    rstN = 1'b1;
    bCnt = 0;
    bPerm = 0;
    bLfsr = 8'h01;
    bOut = '0;
    for (int n = 0; n < 10; n++) tick(7, 1'b1, 1'b1, 2'd0, "R1 R6 sequence restart");

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule